// File: doc/BRIEF.md
# Multi-Mode Configurable I/O Port

An eight-pin port whose pins can each be owned by the processor, by the programmable-logic fabric, or by the latched address bus. The processor reaches the port through a byte-wide register interface (address, write data, write strobe, read strobe and registered read data). Through it the processor sets output data, direction, ownership and drive type, and reads back the synchronised pin levels and the enables the pins actually drive.

When a pin is not owned by the processor, a static two-bit configuration input for that pin selects its role. The role is a fabric output (data from a routed macrocell signal, enable from a product-term enable), an address-bit output (always enabled), or a fabric input (never driven). The drive-select register means different things in the two nibbles. On pins 4 to 7 a set bit emulates open drain in logic. On pins 0 to 3 a set bit raises a fast-slew flag for the pad. The raw pin level is always forwarded to the fabric input bus.

Top module: `mmio_port`

## Requirements
- R1: After reset, reads of offsets 1 (data out), 2 (direction), 3 (drive select) and 4 (control) all return 0.
- R2: A write strobe at offsets 1 to 4 stores the write data. Asserting the read strobe for one cycle returns that register on the read data one clock later, and the read data holds its value while the strobe is low.
- R3: Writes to offset 0 (data in) and offset 5 (output enable) change no register and no output.
- R4: When a pin's control bit (offset 4) is 1, the pin drives its data-out bit (offset 1), and its enable is its direction bit (offset 2, 1 = output).
- R5: When the control bit is 0 and the pin's configuration code (src_cfg_i bits 2i+1:2i) is 0, the pin drives mc_out_i[i] with enable pt_oe_i[i].
- R6: With control bit 0 and code 1, the pin drives addr_bit_i[i] with the enable held at 1.
- R7: With control bit 0 and code 2 or 3, the pin's enable is 0.
- R8: On pins 4 to 7, a drive-select bit of 1 turns a selected 0 into an enabled low and a selected 1 into a released pin (enable 0, data 0).
- R9: fast_slew_o[i] equals drive-select bit i for pins 0 to 3, and those bits never cause open-drain behaviour.
- R10: A read of offset 0 returns the pin level after a two-flop synchroniser, so a change on pin_in_i is seen by a read issued two cycles after the change, and not by a read issued in the same cycle.
- R11: fab_in_o equals pin_in_i in every mode.
- R12: A read of offset 5 returns the current pin_oe_o, including any open-drain change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe |
| reg_rdata_o | output | 8 | Registered read data |
| src_cfg_i | input | 16 | Static per-pin role code, two bits per pin |
| mc_out_i | input | 8 | Routed macrocell output bits |
| pt_oe_i | input | 8 | Product-term output enables |
| addr_bit_i | input | 8 | Latched address bits |
| pin_in_i | input | 8 | Pad input levels |
| pin_out_o | output | 8 | Pad output data |
| pin_oe_o | output | 8 | Pad tristate enables, 1 = drive |
| fast_slew_o | output | 4 | Fast-slew flags for pins 0 to 3 |
| fab_in_o | output | 8 | Pin levels to the fabric input bus |

## Verification
The hardest case to reach is the mix of open-drain emulation with every source in every ownership mode. This matters most when the upper-nibble enable collapses only because the selected data happens to be 1. The bench sweeps all five ownership settings against sixteen arithmetic patterns for data, direction, drive select and the fabric inputs, so each upper pin meets both data polarities with open drain on and off. It also reads offset 5 to confirm that the reported enable matches the pad enable. The synchroniser latency is checked by changing the pin level in the same cycle as a read strobe.

// File: rtl/mmio_port_pkg.sv
package mmio_port_pkg;
  typedef enum logic [2:0] {
    OFF_DIN  = 3'd0,
    OFF_DOUT = 3'd1,
    OFF_DIR  = 3'd2,
    OFF_DRV  = 3'd3,
    OFF_CTRL = 3'd4,
    OFF_OE   = 3'd5
  } reg_off_e;

  typedef enum logic [1:0] {
    SRC_MCELL = 2'd0,
    SRC_ADDR  = 2'd1,
    SRC_IN0   = 2'd2,
    SRC_IN1   = 2'd3
  } pin_src_e;
endpackage

// File: rtl/mmio_port_sync.sv
module mmio_port_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/mmio_port_regs.sv
module mmio_port_regs
  import mmio_port_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [W-1:0]  din_i,
  input  logic [W-1:0]  oe_i,
  output logic [W-1:0]  dout_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  drive_q,
  output logic [W-1:0]  ctrl_q,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= '0;
      dir_q   <= '0;
      drive_q <= '0;
      ctrl_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFF_DOUT: dout_q  <= wdata_i;
        OFF_DIR:  dir_q   <= wdata_i;
        OFF_DRV:  drive_q <= wdata_i;
        OFF_CTRL: ctrl_q  <= wdata_i;
        default: ;  // data in, output enable: read-only
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      OFF_DIN:  rd_mux = din_i;
      OFF_DOUT: rd_mux = dout_q;
      OFF_DIR:  rd_mux = dir_q;
      OFF_DRV:  rd_mux = drive_q;
      OFF_CTRL: rd_mux = ctrl_q;
      OFF_OE:   rd_mux = oe_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/mmio_port_pin.sv
module mmio_port_pin
  import mmio_port_pkg::*;
#(
  parameter bit OD_CAP = 1'b0
) (
  input  logic       ctrl_i,
  input  logic [1:0] src_i,
  input  logic       drv_i,
  input  logic       dout_i,
  input  logic       dir_i,
  input  logic       mc_i,
  input  logic       pt_i,
  input  logic       ad_i,
  output logic       out_o,
  output logic       oe_o
);
  logic dat, en_raw, od_en;

  always_comb begin
    if (ctrl_i) begin
      dat    = dout_i;
      en_raw = dir_i;
    end else begin
      case (pin_src_e'(src_i))
        SRC_MCELL: begin dat = mc_i; en_raw = pt_i; end
        SRC_ADDR:  begin dat = ad_i; en_raw = 1'b1; end
        default:   begin dat = 1'b0; en_raw = 1'b0; end
      endcase
    end
  end

  // Open drain: only a low is ever driven; a high releases the pin
  assign od_en = OD_CAP && drv_i;
  assign out_o = od_en ? 1'b0 : dat;
  assign oe_o  = od_en ? (en_raw & ~dat) : en_raw;
endmodule

// File: rtl/mmio_port.sv
module mmio_port
  import mmio_port_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [W-1:0]    reg_wdata_i,
  input  logic            reg_we_i,
  input  logic            reg_re_i,
  output logic [W-1:0]    reg_rdata_o,
  input  logic [2*W-1:0]  src_cfg_i,
  input  logic [W-1:0]    mc_out_i,
  input  logic [W-1:0]    pt_oe_i,
  input  logic [W-1:0]    addr_bit_i,
  input  logic [W-1:0]    pin_in_i,
  output logic [W-1:0]    pin_out_o,
  output logic [W-1:0]    pin_oe_o,
  output logic [W/2-1:0]  fast_slew_o,
  output logic [W-1:0]    fab_in_o
);
  localparam int LOW = W / 2;

  logic [W-1:0] dout_q, dir_q, drive_q, ctrl_q, din_sync;

  mmio_port_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_in_i),
    .q_o   (din_sync)
  );

  mmio_port_regs #(.W(W), .AW(AW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .we_i   (reg_we_i),
    .re_i   (reg_re_i),
    .din_i  (din_sync),
    .oe_i   (pin_oe_o),
    .dout_q (dout_q),
    .dir_q  (dir_q),
    .drive_q(drive_q),
    .ctrl_q (ctrl_q),
    .rdata_o(reg_rdata_o)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    mmio_port_pin #(.OD_CAP(i >= LOW)) u_pin (
      .ctrl_i(ctrl_q[i]),
      .src_i (src_cfg_i[2*i +: 2]),
      .drv_i (drive_q[i]),
      .dout_i(dout_q[i]),
      .dir_i (dir_q[i]),
      .mc_i  (mc_out_i[i]),
      .pt_i  (pt_oe_i[i]),
      .ad_i  (addr_bit_i[i]),
      .out_o (pin_out_o[i]),
      .oe_o  (pin_oe_o[i])
    );
  end

  assign fast_slew_o = drive_q[LOW-1:0];
  assign fab_in_o    = pin_in_i;
endmodule

// File: rtl/mmio_port_chk.sv
module mmio_port_chk #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [AW-1:0]  reg_addr_i,
  input logic [W-1:0]   reg_wdata_i,
  input logic           reg_we_i,
  input logic           reg_re_i,
  input logic [W-1:0]   reg_rdata_o,
  input logic [2*W-1:0] src_cfg_i,
  input logic [W-1:0]   addr_bit_i,
  input logic [W-1:0]   pin_out_o,
  input logic [W-1:0]   pin_oe_o,
  input logic [W/2-1:0] fast_slew_o,
  input logic [W-1:0]   dout_q,
  input logic [W-1:0]   dir_q,
  input logic [W-1:0]   drive_q,
  input logic [W-1:0]   ctrl_q
);
  localparam int LOW = W / 2;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |=> $stable(reg_rdata_o)); // R2

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && (reg_addr_i == AW'(0) || reg_addr_i == AW'(5)))
    |=> ($stable(dout_q) && $stable(dir_q) && $stable(drive_q) && $stable(ctrl_q))); // R3

  AST_SLEW_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == AW'(3)) |=> fast_slew_o == $past(reg_wdata_i[LOW-1:0])); // R9

  for (genvar i = 0; i < W; i++) begin : g_pin
    AST_ADDR_MODE_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_q[i] && src_cfg_i[2*i +: 2] == 2'd1 && !(i >= LOW && drive_q[i]))
      |-> (pin_oe_o[i] && pin_out_o[i] == addr_bit_i[i])); // R6

    AST_INPUT_MODE_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_q[i] && src_cfg_i[2*i+1]) |-> !pin_oe_o[i]); // R7

    if (i >= LOW) begin : g_od
      AST_OD_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drive_q[i] |-> !(pin_oe_o[i] && pin_out_o[i])); // R8
    end
  end
endmodule

bind mmio_port mmio_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_we_i   (reg_we_i),
  .reg_re_i   (reg_re_i),
  .reg_rdata_o(reg_rdata_o),
  .src_cfg_i  (src_cfg_i),
  .addr_bit_i (addr_bit_i),
  .pin_out_o  (pin_out_o),
  .pin_oe_o   (pin_oe_o),
  .fast_slew_o(fast_slew_o),
  .dout_q     (dout_q),
  .dir_q      (dir_q),
  .drive_q    (drive_q),
  .ctrl_q     (ctrl_q)
);

// File: tb/mmio_port_bench.sv
`timescale 1ns/1ps
module mmio_port_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic        reg_we_i = 1'b0;
  logic        reg_re_i = 1'b0;
  logic [7:0]  reg_rdata_o;
  logic [15:0] src_cfg_i = '0;
  logic [7:0]  mc_out_i = '0, pt_oe_i = '0, addr_bit_i = '0, pin_in_i = '0;
  logic [7:0]  pin_out_o, pin_oe_o, fab_in_o;
  logic [3:0]  fast_slew_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mmio_port u_mmio_port (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_re_i = 1'b1;
    @(negedge clk_i);
    reg_re_i = 1'b0;
    d = reg_rdata_o;
  endtask

  // Expected pin behaviour from R4..R8
  task automatic model(logic [7:0] ctl, logic [1:0] cfg, logic [7:0] drv, logic [7:0] dout,
                       logic [7:0] dir, logic [7:0] mc, logic [7:0] pt, logic [7:0] ad,
                       output logic [7:0] eo, output logic [7:0] ee);
    for (int i = 0; i < 8; i++) begin
      logic d, e;
      if (ctl[i])          begin d = dout[i]; e = dir[i]; end
      else if (cfg == 2'd0) begin d = mc[i];   e = pt[i];  end
      else if (cfg == 2'd1) begin d = ad[i];   e = 1'b1;   end
      else                  begin d = 1'b0;    e = 1'b0;   end
      if (i >= 4 && drv[i]) begin e = e & ~d; d = 1'b0; end
      eo[i] = d; ee[i] = e;
    end
  endtask

  function automatic string mode_tag(int m);
    case (m)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    logic [7:0] r, eo, ee;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int a = 1; a <= 4; a++) begin
      rd(3'(a), r); chk("R1 reset value", r, 8'h00);
    end

    wr(3'd1, 8'h5A); wr(3'd2, 8'hC3); wr(3'd3, 8'h96); wr(3'd4, 8'h0F);
    rd(3'd1, r); chk("R2 data out", r, 8'h5A);
    rd(3'd2, r); chk("R2 direction", r, 8'hC3);
    rd(3'd3, r); chk("R2 drive select", r, 8'h96);
    rd(3'd4, r); chk("R2 control", r, 8'h0F);
    repeat (3) @(negedge clk_i);
    chk("R2 read data held", reg_rdata_o, 8'h0F);

    // R3: read-only offsets
    pin_in_i = 8'h3C;
    repeat (3) @(negedge clk_i);
    eo = pin_out_o; ee = pin_oe_o;
    wr(3'd0, 8'hA5); wr(3'd5, 8'hFF);
    #1;
    chk("R3 out unchanged", pin_out_o, eo);
    chk("R3 oe unchanged", pin_oe_o, ee);
    rd(3'd0, r); chk("R3 data in unaffected", r, 8'h3C);
    rd(3'd1, r); chk("R3 data out kept", r, 8'h5A);
    rd(3'd3, r); chk("R3 drive kept", r, 8'h96);
    rd(3'd4, r); chk("R3 control kept", r, 8'h0F);

    // R10: synchroniser latency
    @(negedge clk_i);
    pin_in_i = 8'hE1;
    reg_addr_i = 3'd0; reg_re_i = 1'b1;
    @(negedge clk_i);
    reg_re_i = 1'b0;
    chk("R10 same-cycle read sees old", reg_rdata_o, 8'h3C);
    rd(3'd0, r);
    rd(3'd0, r); chk("R10 read after two cycles", r, 8'hE1);

    // R8/R9 directed
    src_cfg_i = '0;
    wr(3'd4, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hF0); wr(3'd1, 8'hF0);
    #1;
    chk("R8 released highs", pin_oe_o, 8'h0F);
    chk("R8 no driven high", pin_out_o, 8'h00);
    wr(3'd1, 8'h0F);
    #1;
    chk("R8 driven lows", pin_oe_o, 8'hFF);
    wr(3'd3, 8'h0F); wr(3'd1, 8'hF0);
    #1;
    chk("R9 lower bits not open drain oe", pin_oe_o, 8'hFF);
    chk("R9 lower bits not open drain out", pin_out_o, 8'hF0);
    chk("R9 fast slew", {4'h0, fast_slew_o}, 8'h0F);

    // Sweep: five ownership settings x sixteen patterns
    for (int m = 0; m < 5; m++) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0] dout, dir, drv, ctl, mc, pt, ad, pin;
        logic [1:0] cfg;
        dout = 8'(k * 29 + 3);  dir = 8'(k * 53 + 7);  drv = 8'(k * 71 + 11);
        mc   = 8'(k * 97 + 5);  pt  = 8'(k * 113 + 9); ad  = 8'(k * 41 + 13);
        pin  = 8'(k * 59 + 1);
        ctl  = (m == 0) ? 8'hFF : 8'h00;
        cfg  = (m == 0) ? 2'(k) : 2'(m - 1);
        wr(3'd1, dout); wr(3'd2, dir); wr(3'd3, drv); wr(3'd4, ctl);
        src_cfg_i = {8{cfg}};
        mc_out_i = mc; pt_oe_i = pt; addr_bit_i = ad; pin_in_i = pin;
        #1;
        model(ctl, cfg, drv, dout, dir, mc, pt, ad, eo, ee);
        chk({mode_tag(m), " R8 pin data"}, pin_out_o, eo);
        chk({mode_tag(m), " R8 pin enable"}, pin_oe_o, ee);
        chk("R9 fast slew flags", {4'h0, fast_slew_o}, {4'h0, drv[3:0]});
        chk("R11 fabric input", fab_in_o, pin);
        rd(3'd5, r); chk("R12 enable readback", r, ee);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule